// File: doc/BRIEF.md
# Approximate Log2 / Antilog2 Conversion Unit

This unit converts values between a linear fixed-point domain and an approximate base-2 logarithmic domain in one clocked stage. A 48-bit source word and a 3-bit operation code are presented together with an issue strobe. On the next rising clock edge the selected result is written into a 48-bit result register. The result register keeps its value until another operation is issued.

The linear domain is an unsigned number with 25 integer bits and 23 fraction bits, so 1.0 is `0x000000800000`. The log domain is an unsigned number with 5 integer bits and 4 fraction bits, held in bits 8:0 of the word. The logarithm is formed from the position of the leading one, and the four bits just below that leading one give a linear approximation of the mantissa. The inverse conversion rebuilds the value as a shifted 1.0 scaled by (1 + fraction/16). The same stage can also negate a value, take its absolute value, or copy the source unchanged. Software that needs gain scaling in the log domain uses the unit to map samples there and back without a full transcendental evaluator.

Top module: `lgx_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the result output reads 0 until the first operation is issued.
- R2: An operation issued with `issue_i` high at a rising edge drives its result on `res_o` right after that edge. With `issue_i` low the result register holds its value, whatever `op_sel_i` and `src_i` are.
- R3: Operation code 0 copies `src_i` to the result unchanged. The unused codes 5, 6 and 7 behave the same way.
- R4: Code 1 gives the two's-complement negation of `src_i` modulo 2^48. The most negative value `0x800000000000` maps to itself.
- R5: Code 2 gives the absolute value of `src_i` read as signed: non-negative inputs are unchanged and negative inputs are negated. `0x800000000000` saturates to `0x7FFFFFFFFFFF`.
- R6: Code 3 (log2) returns the integer part (leading-one bit position minus 23) in bits 8:4 and the four source bits just below the leading one in bits 3:0. Bits 47:9 are zero.
- R7: Under code 3, any source at or below 1.0 (`0x000000800000`), including zero, gives a result of 0.
- R8: Under code 3, an exact power of two 2^k with k from 23 to 47 gives exactly (k-23)·16. Converting that code back with code 4 returns 2^k exactly.
- R9: Code 4 (antilog2) reads only bits 8:0 of the source, as integer i = bits 8:4 and fraction f = bits 3:0. For i ≤ 24 it returns (16+f)·2^(i+19). Bits 47:9 of the source have no effect.
- R10: Under code 4, an integer part i greater than 24 saturates the result to `0xFFFFFFFFFFFF`.
- R11: For any source x above 1.0, applying log2 and then antilog2 gives a value y with y ≤ x and x − y ≤ x/16 (integer division).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Starts the selected operation at this clock edge |
| op_sel_i | input | 3 | Operation code: 0 pass, 1 negate, 2 absolute, 3 log2, 4 antilog2, 5-7 pass |
| src_i | input | 48 | Source word (linear, signed or packed log code) |
| res_o | output | 48 | Registered result |

## Verification
The hardest conditions to reach are the edges of the antilog range and of the signed operations. An integer part of exactly 24 with a full fraction must still fit, while 25 must saturate. The most negative word must be kept apart under negate and under absolute value. From the ports these conditions can only be reached with exact bit patterns. The stimulus therefore writes the packed log codes `0x18F`, `0x190` and `0x1FF` directly into the source, and sets the antilog upper bits to ones to show they are ignored. It also sweeps every power of two through log2 and back, and runs non-power values through the round trip to bound the truncation error.

// File: rtl/lgx_pkg.sv
package lgx_pkg;
    // Linear word: unsigned, LIN_FRAC_W fraction bits
    localparam int unsigned DATA_W     = 48;
    localparam int unsigned LIN_FRAC_W = 23;
    // Log code: LOG_INT_W integer bits, LOG_FRAC_W fraction bits
    localparam int unsigned LOG_INT_W  = 5;
    localparam int unsigned LOG_FRAC_W = 4;

    localparam int unsigned LOG_W   = LOG_INT_W + LOG_FRAC_W;
    localparam int unsigned POS_W   = $clog2(DATA_W);
    // Largest integer part whose antilog still fits in DATA_W bits
    localparam int unsigned MAX_INT = DATA_W - LIN_FRAC_W - 1;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_NEG  = 3'd1,
        OP_ABS  = 3'd2,
        OP_LOG  = 3'd3,
        OP_ALOG = 3'd4
    } lgx_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
    } lgx_state_t;
endpackage

// File: rtl/lgx_lead_one.sv
module lgx_lead_one #(
    parameter int unsigned WIDTH = 48,
    localparam int unsigned PW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [PW-1:0]    pos_o,
    output logic             any_o
);
    // Scan upward so the highest set bit wins
    always_comb begin
        pos_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < int'(WIDTH); i++) begin
            if (vec_i[i]) begin
                pos_o = PW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lgx_log2_core.sv
module lgx_log2_core
    import lgx_pkg::*;
(
    input  logic [DATA_W-1:0] lin_i,
    output logic [DATA_W-1:0] log_o
);
    localparam logic [DATA_W-1:0] ONE_LIN = DATA_W'(1) << LIN_FRAC_W;

    logic [POS_W-1:0]      lead_pos;
    logic                  lead_any;
    logic [POS_W-1:0]      int_part;
    logic [POS_W-1:0]      shift_amt;
    logic [DATA_W-1:0]     shifted;
    logic [LOG_FRAC_W-1:0] frac_part;

    lgx_lead_one #(.WIDTH(DATA_W)) lead_i (
        .vec_i (lin_i),
        .pos_o (lead_pos),
        .any_o (lead_any)
    );

    always_comb begin
        int_part  = lead_pos - POS_W'(LIN_FRAC_W);
        shift_amt = (lead_pos >= POS_W'(LOG_FRAC_W)) ?
                    lead_pos - POS_W'(LOG_FRAC_W) : '0;
        shifted   = lin_i >> shift_amt;
        frac_part = shifted[LOG_FRAC_W-1:0];
        log_o     = '0;
        if (lead_any && (lin_i > ONE_LIN)) begin
            log_o[LOG_W-1:LOG_FRAC_W] = int_part[LOG_INT_W-1:0];
            log_o[LOG_FRAC_W-1:0]     = frac_part;
        end
    end
endmodule

// File: rtl/lgx_alog2_core.sv
module lgx_alog2_core
    import lgx_pkg::*;
(
    input  logic [DATA_W-1:0] code_i,
    output logic [DATA_W-1:0] lin_o
);
    localparam int unsigned SH_W = POS_W + 1;

    logic [LOG_INT_W-1:0]  int_part;
    logic [LOG_FRAC_W-1:0] frac_part;
    logic [DATA_W-1:0]     mant;
    logic [SH_W-1:0]       shift_amt;
    logic                  saturate;

    always_comb begin
        int_part  = code_i[LOG_W-1:LOG_FRAC_W];
        frac_part = code_i[LOG_FRAC_W-1:0];
        mant      = DATA_W'({1'b1, frac_part});
        shift_amt = SH_W'(int_part) + SH_W'(LIN_FRAC_W - LOG_FRAC_W);
        saturate  = (32'(int_part) > MAX_INT);
        lin_o     = saturate ? '1 : (mant << shift_amt);
    end
endmodule

// File: rtl/lgx_sign_ops.sv
module lgx_sign_ops
    import lgx_pkg::*;
(
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] neg_o,
    output logic [DATA_W-1:0] abs_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        neg_o = (~val_i) + DATA_W'(1);
        if (val_i == MOST_NEG)
            abs_o = MOST_POS;
        else if (val_i[DATA_W-1])
            abs_o = neg_o;
        else
            abs_o = val_i;
    end
endmodule

// File: rtl/lgx_unit.sv
module lgx_unit
    import lgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [2:0]        op_sel_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] res_o
);
    lgx_state_t state_d, state_q;

    logic [DATA_W-1:0] log_val;
    logic [DATA_W-1:0] alog_val;
    logic [DATA_W-1:0] neg_val;
    logic [DATA_W-1:0] abs_val;

    lgx_log2_core log_i (
        .lin_i (src_i),
        .log_o (log_val)
    );

    lgx_alog2_core alog_i (
        .code_i (src_i),
        .lin_o  (alog_val)
    );

    lgx_sign_ops sign_i (
        .val_i (src_i),
        .neg_o (neg_val),
        .abs_o (abs_val)
    );

    always_comb begin
        state_d = state_q;
        if (issue_i) begin
            case (op_sel_i)
                OP_NEG:  state_d.res = neg_val;
                OP_ABS:  state_d.res = abs_val;
                OP_LOG:  state_d.res = log_val;
                OP_ALOG: state_d.res = alog_val;
                default: state_d.res = src_i;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign res_o = state_q.res;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> $stable(res_o));

    // R3
    pass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_sel_i == 3'd0) |=> (res_o == $past(src_i)));

    // R4
    neg_sum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_sel_i == 3'd1) |=> (DATA_W'(res_o + $past(src_i)) == '0));

    // R5
    abs_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_sel_i == 3'd2) |=> !res_o[DATA_W-1]);

    // R6
    log_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_sel_i == 3'd3) |=> (res_o[DATA_W-1:LOG_W] == '0));

    // R10
    alog_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_sel_i == 3'd4 && 32'(src_i[LOG_W-1:LOG_FRAC_W]) > MAX_INT)
        |=> (&res_o));
endmodule

// File: tb/lgx_unit_tb_top.sv
module lgx_unit_tb_top;
    localparam int DW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic [2:0]    op_sel_i = 3'd0;
    logic [DW-1:0] src_i = '0;
    logic [DW-1:0] res_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lgx_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue_i),
        .op_sel_i (op_sel_i),
        .src_i    (src_i),
        .res_o    (res_o)
    );

    typedef struct packed {
        logic [7:0]    req;
        logic [2:0]    op;
        logic [DW-1:0] src;
        logic [DW-1:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  3'd0, 48'h123456789ABC, 48'h123456789ABC}, // R3 pass
        '{8'd3,  3'd6, 48'h0000DEADBEEF, 48'h0000DEADBEEF}, // R3 unused code
        '{8'd4,  3'd1, 48'h000000000005, 48'hFFFFFFFFFFFB}, // R4
        '{8'd4,  3'd1, 48'h800000000000, 48'h800000000000}, // R4 most negative
        '{8'd5,  3'd2, 48'hFFFFFFFFFFFB, 48'h000000000005}, // R5
        '{8'd5,  3'd2, 48'h800000000000, 48'h7FFFFFFFFFFF}, // R5 saturate
        '{8'd5,  3'd2, 48'h000000001234, 48'h000000001234}, // R5 positive
        '{8'd7,  3'd3, 48'h000000000000, 48'h000000000000}, // R7 zero
        '{8'd7,  3'd3, 48'h000000800000, 48'h000000000000}, // R7 exactly 1.0
        '{8'd6,  3'd3, 48'h000000C00000, 48'h000000000008}, // R6 1.5
        '{8'd6,  3'd3, 48'h000003000000, 48'h000000000028}, // R6 6.0
        '{8'd8,  3'd3, 48'h800000000000, 48'h000000000180}, // R8 top power
        '{8'd9,  3'd4, 48'h000000000000, 48'h000000800000}, // R9
        '{8'd9,  3'd4, 48'h000000000028, 48'h000003000000}, // R9
        '{8'd9,  3'd4, 48'h00000000018F, 48'hF80000000000}, // R9 largest fit
        '{8'd10, 3'd4, 48'h000000000190, 48'hFFFFFFFFFFFF}, // R10
        '{8'd9,  3'd4, 48'hFFFFFFFFF008, 48'h000000C00000}, // R9 upper ignored
        '{8'd10, 3'd4, 48'h0000000001FF, 48'hFFFFFFFFFFFF}  // R10
    };

    task automatic check(input string tag, input logic [DW-1:0] got,
                         input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive on the falling edge, result sampled one full cycle later
    task automatic apply(input logic [2:0] op, input logic [DW-1:0] src,
                         output logic [DW-1:0] res);
        @(negedge clk);
        issue_i  = 1'b1;
        op_sel_i = op;
        src_i    = src;
        @(negedge clk);
        issue_i  = 1'b0;
        res      = res_o;
    endtask

    initial begin
        logic [DW-1:0] r1, r2, held;
        logic [DW-1:0] rt_vals [6];
        rt_vals = '{48'h000000C12345, 48'h0000FFFFFFFF, 48'h7FFFFFFFFFFF,
                    48'h000000800001, 48'h123456789ABC, 48'hFFFFFFFFFFFF};

        repeat (3) @(negedge clk);
        check("R1 reset value", res_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 after release", res_o, '0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].src, r1);
            checks++;
            if (r1 !== VECS[i].exp) begin
                fails++;
                $display("FAIL vector %0d (R%0d): got %h expected %h",
                         i, VECS[i].req, r1, VECS[i].exp);
            end
        end

        // R2: hold while idle
        apply(3'd0, 48'h00000000A5A5, held);
        check("R2 issued value", held, 48'h00000000A5A5);
        @(negedge clk);
        op_sel_i = 3'd1;
        src_i    = 48'h000000000777;
        repeat (3) @(negedge clk);
        check("R2 hold when idle", res_o, 48'h00000000A5A5);

        // R8: exact powers of two, and back
        for (int k = 23; k < DW; k++) begin
            apply(3'd3, DW'(1) << k, r1);
            check("R8 log2 power", r1, DW'((k - 23) * 16));
            apply(3'd4, r1, r2);
            check("R8 round trip power", r2, DW'(1) << k);
        end

        // R11: round-trip error bound
        for (int j = 0; j < 6; j++) begin
            apply(3'd3, rt_vals[j], r1);
            apply(3'd4, r1, r2);
            checks++;
            if (!(r2 <= rt_vals[j] && (rt_vals[j] - r2) <= (rt_vals[j] >> 4))) begin
                fails++;
                $display("FAIL R11 round trip: got %h expected within x/16 below %h",
                         r2, rt_vals[j]);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule